// File: doc/BRIEF.md
# 4B/5B Receive Aligner and Decoder

This block sits behind the descrambler in a 100 Mb/s receive path. It takes an unframed serial stream, one bit per `bit_stb` pulse, and finds the 5-bit code-group boundary by spotting the start-of-stream pair J/K. J/K counts as a start only after a long enough run of IDLE. Once a packet is open, every fifth bit closes a code-group. Each code-group is translated into a 4-bit nibble and presented on a receive interface in the style of an MII: `rxd`, `rx_dv`, `rx_er` and a one-cycle `nib_stb`.

The J/K pair itself is delivered as two preamble nibbles. The data groups that follow are translated with one code-group of latency. That latency lets the block tell an end pair T/R apart from a stray T before anything is emitted. The packet closes on T/R, or at once when either `link_ok` or `sig_det` drops. Code-groups that are not data are flagged on `rx_er`. All logic runs on `clk`. The block does not cross into a separate receive clock.

Top module: `rx_5b4b_align`

## Requirements
- R1: The group boundary is taken from the bit at which the last 10 received bits equal 1100010001, the first-received bit being the leftmost. This match may occur at any bit offset. Every later group is the next 5 bits at that fixed offset, first-received bit as the group's MSB.
- R2: A start is accepted only if three conditions hold. `link_ok` and `sig_det` must both be high. No packet may already be open. The run of consecutive 1 bits that ends at J's first 0 must be at least IDLE_MIN_BITS+2 long (12 by default, i.e. ten IDLE bits plus J's two leading ones).
- R3: J and K are each delivered as one nibble 0101 with `rx_er` low. `rx_dv` rises in the same cycle as the J nibble.
- R4: Data groups translate as follows. 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. `rxd[0]` is the nibble's LSB. Each nibble is delivered when the following group completes.
- R5: While a packet is open, `nib_stb` pulses for exactly one clock, in the cycle after every fifth `bit_stb`. `rxd` and `rx_er` hold steady between pulses.
- R6: Suppose a T (01101) is pending and the next group is R (00111). Then `rx_dv` and `rx_er` fall in the cycle after R's last bit, no strobe is issued, and neither T nor R appears on `rxd`.
- R7: Any group that is not one of the 16 data groups raises `rx_er` with `rxd` = 0000, and `rx_dv` stays high. This covers IDLE, J, K, a T not followed by R, and unused codes.
- R8: If `link_ok` or `sig_det` is low while a packet is open, `rx_dv` is low in the next cycle. No strobe follows until a new accepted start.
- R9: During reset and in the first cycle after it, `rxd`, `rx_dv`, `rx_er` and `nib_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Descrambled serial bit |
| bit_stb | input | 1 | Qualifies `bit_in` for one clock |
| link_ok | input | 1 | Link integrity indication |
| sig_det | input | 1 | Signal energy present |
| rxd | output | 4 | Decoded nibble, bit 0 is the LSB |
| rx_dv | output | 1 | Packet data valid |
| rx_er | output | 1 | Current nibble came from a non-data group |
| nib_stb | output | 1 | One-clock pulse per delivered nibble |

## Verification
The bench varies the idle length before each packet, so J/K lands on every one of the five bit offsets. A design that fixed the boundary anywhere except at the match would garble the data nibble. It tries idle runs one bit short of the minimum and exactly at the minimum. A wrong comparison would either open spurious packets or miss valid ones. A T followed by something other than R must come out as an error with the packet still open; a decoder that ended on T alone would drop `rx_dv` early. Dropping `sig_det` in mid-packet, and holding `link_ok` low across a whole valid start, expose a design that keeps strobing or opens a packet on a dead line.

// File: rtl/rx_5b4b_align.sv
module rx_5b4b_align #(
  parameter int IDLE_MIN_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_stb,
  input  logic       link_ok,
  input  logic       sig_det,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       nib_stb
);
  localparam int RUN_MAX = IDLE_MIN_BITS + 2;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [9:0] PAT_JK = 10'b11000_10001;
  localparam logic [4:0] G_T    = 5'b01101;
  localparam logic [4:0] G_R    = 5'b00111;
  localparam logic [3:0] PREAMB = 4'b0101;

  function automatic logic [4:0] dec5(input logic [4:0] c);
    case (c)
      5'b11110: return 5'h10;
      5'b01001: return 5'h11;
      5'b10100: return 5'h12;
      5'b10101: return 5'h13;
      5'b01010: return 5'h14;
      5'b01011: return 5'h15;
      5'b01110: return 5'h16;
      5'b01111: return 5'h17;
      5'b10010: return 5'h18;
      5'b10011: return 5'h19;
      5'b10110: return 5'h1A;
      5'b10111: return 5'h1B;
      5'b11010: return 5'h1C;
      5'b11011: return 5'h1D;
      5'b11100: return 5'h1E;
      5'b11101: return 5'h1F;
      default:  return 5'h00;
    endcase
  endfunction

  logic [9:0]       sr;
  logic [RUN_W-1:0] run_cur, run_p1, run_p2;
  logic             in_pkt;
  logic [2:0]       phase;
  logic [3:0]       pend_nib;
  logic             pend_err, pend_t;

  wire [9:0] sr_nxt  = {sr[8:0], bit_in};
  wire [4:0] grp     = sr_nxt[4:0];
  wire [4:0] grp_dec = dec5(grp);
  wire       line_up = link_ok & sig_det;
  wire       idle_ok = run_p2 >= RUN_W'(RUN_MAX);
  wire       jk_hit  = !in_pkt && bit_stb && line_up && (sr_nxt == PAT_JK) && idle_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      run_cur  <= '0;
      run_p1   <= '0;
      run_p2   <= '0;
      in_pkt   <= 1'b0;
      phase    <= '0;
      pend_nib <= '0;
      pend_err <= 1'b0;
      pend_t   <= 1'b0;
      rxd      <= '0;
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
      nib_stb  <= 1'b0;
    end else begin
      nib_stb <= 1'b0;
      if (bit_stb) begin
        sr <= sr_nxt;
        if (bit_in) begin
          if (run_cur != RUN_W'(RUN_MAX)) run_cur <= run_cur + 1'b1;
        end else begin
          if (run_cur != '0) begin
            run_p2 <= run_p1;
            run_p1 <= run_cur;
          end
          run_cur <= '0;
        end
      end

      if (in_pkt && !line_up) begin
        in_pkt <= 1'b0;
        rx_dv  <= 1'b0;
        rx_er  <= 1'b0;
        rxd    <= '0;
      end else if (jk_hit) begin
        in_pkt   <= 1'b1;
        phase    <= '0;
        rxd      <= PREAMB;
        rx_dv    <= 1'b1;
        rx_er    <= 1'b0;
        nib_stb  <= 1'b1;
        pend_nib <= PREAMB;
        pend_err <= 1'b0;
        pend_t   <= 1'b0;
      end else if (in_pkt && bit_stb) begin
        if (phase == 3'd4) begin
          phase <= '0;
          if (pend_t && grp == G_R) begin
            in_pkt <= 1'b0;
            rx_dv  <= 1'b0;
            rx_er  <= 1'b0;
            rxd    <= '0;
          end else begin
            rxd      <= pend_err ? 4'h0 : pend_nib;
            rx_er    <= pend_err;
            nib_stb  <= 1'b1;
            pend_nib <= grp_dec[3:0];
            pend_err <= !grp_dec[4];
            pend_t   <= (grp == G_T);
          end
        end else begin
          phase <= phase + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_5b4b_align_chk.sv
module rx_5b4b_align_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic       link_ok,
  input logic       sig_det,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       nib_stb
);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rx_dv && !rx_er && !nib_stb && rxd == 4'h0));

  a_r8_line_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok || !sig_det) |=> !rx_dv);

  a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (nib_stb && rxd == 4'b0101 && !rx_er));

  a_r5_stb_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> ($past(bit_stb) && rx_dv));

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !nib_stb) |-> ($stable(rxd) && $stable(rx_er)));

  a_r7_er_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> (rx_dv && rxd == 4'h0));
endmodule

bind rx_5b4b_align rx_5b4b_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .link_ok(link_ok),
  .sig_det(sig_det), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .nib_stb(nib_stb)
);

// File: tb/rx_5b4b_align_tb.sv
module rx_5b4b_align_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b1, bit_stb = 1'b0, link_ok = 1'b1, sig_det = 1'b1;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, nib_stb;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, log_n = 0;
  logic [3:0] log_nib [256];
  logic       log_er  [256];
  int         log_cyc [256];

  rx_5b4b_align u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .link_ok(link_ok), .sig_det(sig_det),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .nib_stb(nib_stb)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (nib_stb) begin
      log_nib[log_n[7:0]] <= rxd;
      log_er[log_n[7:0]]  <= rx_er;
      log_cyc[log_n[7:0]] <= cyc;
      log_n <= log_n + 1;
    end
  end

  // {code, nibble, error}
  localparam logic [9:0] VEC [21] = '{
    {5'b11110, 4'h0, 1'b0}, {5'b01001, 4'h1, 1'b0}, {5'b10100, 4'h2, 1'b0},
    {5'b10101, 4'h3, 1'b0}, {5'b01010, 4'h4, 1'b0}, {5'b01011, 4'h5, 1'b0},
    {5'b01110, 4'h6, 1'b0}, {5'b01111, 4'h7, 1'b0}, {5'b10010, 4'h8, 1'b0},
    {5'b10011, 4'h9, 1'b0}, {5'b10110, 4'hA, 1'b0}, {5'b10111, 4'hB, 1'b0},
    {5'b11010, 4'hC, 1'b0}, {5'b11011, 4'hD, 1'b0}, {5'b11100, 4'hE, 1'b0},
    {5'b11101, 4'hF, 1'b0}, {5'b00000, 4'h0, 1'b1}, {5'b11000, 4'h0, 1'b1},
    {5'b11111, 4'h0, 1'b1}, {5'b01101, 4'h0, 1'b1}, {5'b00100, 4'h0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int k = 4; k >= 0; k--) send_bit(g[k]);
  endtask

  task automatic send_ones(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1);
  endtask

  task automatic chk_preamble(input int m, input string req);
    chk(log_nib[m[7:0]] == 4'b0101 && !log_er[m[7:0]], req, log_nib[m[7:0]], 4'b0101);
    chk(log_nib[m[7:0]+8'd1] == 4'b0101 && !log_er[m[7:0]+8'd1], req,
        log_nib[m[7:0]+8'd1], 4'b0101);
  endtask

  initial begin
    int mark;
    repeat (3) @(negedge clk);
    chk(rxd == 0 && !rx_dv && !rx_er && !nib_stb, "R9", {rxd, rx_dv, rx_er, nib_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rxd == 0 && !rx_dv && !rx_er && !nib_stb, "R9", {rxd, rx_dv, rx_er, nib_stb}, 0);

    // R1 R3 R4 R6 R7: one data group per packet, J/K at rotating offsets
    for (int i = 0; i < 21; i++) begin
      mark = log_n;
      send_ones(12 + (i % 5));
      send_grp(5'b11000); send_grp(5'b10001);
      send_grp(VEC[i][9:5]);
      send_grp(5'b01101); send_grp(5'b00111);
      send_ones(2);
      chk(log_n - mark == 3 && !rx_dv, "R6", log_n - mark, 3);
      chk_preamble(mark, "R3");
      chk(log_nib[mark[7:0]+8'd2] == VEC[i][4:1] && log_er[mark[7:0]+8'd2] == VEC[i][0],
          VEC[i][0] ? "R7" : "R4 R1",
          {log_er[mark[7:0]+8'd2], log_nib[mark[7:0]+8'd2]}, {VEC[i][0], VEC[i][4:1]});
    end

    // R4 R5: long packet, ordering and strobe spacing
    mark = log_n;
    send_ones(14);
    send_grp(5'b11000); send_grp(5'b10001);
    for (int v = 0; v < 16; v++) send_grp(VEC[v][9:5]);
    send_grp(5'b01101); send_grp(5'b00111);
    send_ones(2);
    chk(log_n - mark == 18, "R5", log_n - mark, 18);
    for (int v = 0; v < 16; v++)
      chk(log_nib[mark[7:0] + 8'(v + 2)] == 4'(v), "R4", log_nib[mark[7:0] + 8'(v + 2)], v);
    for (int v = 1; v < 18; v++)
      chk(log_cyc[mark[7:0] + 8'(v)] - log_cyc[mark[7:0] + 8'(v - 1)] == 15, "R5",
          log_cyc[mark[7:0] + 8'(v)] - log_cyc[mark[7:0] + 8'(v - 1)], 15);

    // R2: idle run one bit short, then exactly at the minimum
    mark = log_n;
    send_grp(5'b00000); send_ones(9);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'b01011);
    send_grp(5'b01101); send_grp(5'b00111); send_ones(1);
    chk(log_n == mark && !rx_dv, "R2", log_n - mark, 0);
    mark = log_n;
    send_grp(5'b00000); send_ones(10);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'b01011);
    send_grp(5'b01101); send_grp(5'b00111); send_ones(1);
    chk(log_n - mark == 3 && log_nib[mark[7:0]+8'd2] == 4'h5, "R2", log_n - mark, 3);

    // R2: no start with link_ok low
    mark = log_n;
    link_ok = 1'b0;
    send_ones(14);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'b01011);
    send_grp(5'b01101); send_grp(5'b00111); send_ones(2);
    chk(log_n == mark && !rx_dv, "R2", log_n - mark, 0);
    link_ok = 1'b1;

    // R7 R6: T followed by a data group, then T/R
    mark = log_n;
    send_ones(13);
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'b01101); send_grp(5'b01011);
    send_grp(5'b01101); send_grp(5'b00111); send_ones(2);
    chk(log_n - mark == 4 && !rx_dv, "R6", log_n - mark, 4);
    chk(log_er[mark[7:0]+8'd2] && log_nib[mark[7:0]+8'd2] == 4'h0, "R7",
        {log_er[mark[7:0]+8'd2], log_nib[mark[7:0]+8'd2]}, 5'h10);
    chk(!log_er[mark[7:0]+8'd3] && log_nib[mark[7:0]+8'd3] == 4'h5, "R4",
        log_nib[mark[7:0]+8'd3], 5);

    // R8: signal lost mid-packet
    mark = log_n;
    send_ones(14);
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'b01001); send_grp(5'b10100);
    chk(rx_dv, "R8", rx_dv, 1);
    sig_det = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!rx_dv, "R8", rx_dv, 0);
    send_grp(5'b10101); send_grp(5'b01010);
    send_grp(5'b01101); send_grp(5'b00111);
    sig_det = 1'b1;
    send_ones(3);
    chk(log_n - mark == 3 && !rx_dv, "R8", log_n - mark, 3);

    // R9: reset during a packet
    send_ones(14);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'b01111);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!rx_dv && !nib_stb && rxd == 0, "R9", {rxd, rx_dv, nib_stb}, 0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule